// File: doc/BRIEF.md
# Inter-computer bus message initiator

This block sends one hardware message from the local CPU to another computer over a shared inter-computer bus. The CPU fills an outgoing record with two words. The first is a header, holding the receiver number in the upper 12 bits and the sender number in the lower 12. The second is the message address word. The CPU then pulses a send strobe.

The block asks the bus arbiter for mastership and waits for the grant. It then drives the header for one cycle and the address word for one cycle. After that it waits for the addressed computer to return one data word. The reply, or a zero on timeout, goes into the record's data slot. A three-bit error status goes into the status slot. When the block releases the bus it interrupts the CPU.

Only one message is in flight at a time. The CPU can see this through a busy flag. The record slots use byte offsets from the information base, matching how the CPU addresses the record: header at 2, address at 4, data at 6 and status at 8.

Top module: `icb_msg_init`

## Requirements
- R1: After reset, busy, irq, bus_req and bus_drive are low and all four record slots read zero.
- R2: A send pulse while idle raises busy and bus_req in the next cycle. bus_req stays high until the message completes, and nothing is driven on the bus until bus_gnt has been seen.
- R3: In the first cycle after the grant, bus_drive is high and bus_out carries the header slot. In the next cycle bus_out carries the address word. bus_drive is high for exactly those two cycles.
- R4: In the driven address word, bit 23 (bit 0 in the message's MSB-first numbering) is forced to 1. All other bits, including bit 22 (command flag) and the buffer address in bits 16..0, pass through as written.
- R5: A reply strobe (bus_rvalid) during the wait phase stores bus_rdata into the data slot (offset 6). In the cycle after the reply, irq pulses high for one cycle while busy and bus_req are low.
- R6: If no reply arrives within TIMEOUT cycles after the address word, the status slot holds only bit 21 (timeout) and the data slot holds zero. A reply in the last cycle of the window is still accepted.
- R7: bus_par is even parity over bus_out. A reply whose parity bit bus_rpar differs from the XOR of bus_rdata sets status bit 22 (parity error), and the data is still stored.
- R8: A reply that arrives while the previous reply has not been consumed sets status bit 23 (overrun). The CPU consumes a reply by reading offset 6 with cpu_rd high. Each message replaces the whole status slot.
- R9: While busy, a send pulse and CPU writes to the header and address slots are ignored. The in-flight message and the slot contents are unchanged, and no second message follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe for record slots |
| cpu_wr_off | input | 4 | Byte offset of written slot (2 header, 4 address) |
| cpu_wdata | input | 24 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe (consumes reply when offset is 6) |
| cpu_rd_off | input | 4 | Byte offset of read slot |
| cpu_rdata | output | 24 | Slot contents at cpu_rd_off |
| cpu_send | input | 1 | Start a message |
| busy | output | 1 | Message in progress |
| irq | output | 1 | One-cycle completion interrupt |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_drive | output | 1 | bus_out valid (header or address cycle) |
| bus_out | output | 24 | Word driven on the bus |
| bus_par | output | 1 | Even parity of bus_out |
| bus_rvalid | input | 1 | Reply word strobe from target |
| bus_rdata | input | 24 | Reply word |
| bus_rpar | input | 1 | Parity bit of reply word |

## Verification
The bench builds the block with TIMEOUT set to 8 instead of the default 64. This short window lets it probe both edges of the wait phase cheaply: a reply in the eighth wait cycle is accepted, and silence through that cycle raises the timeout. With the same build it runs back-to-back messages without consuming the reply to reach the overrun flag, and it corrupts reply parity on purpose.

// File: rtl/icb_msg_init.sv
module icb_msg_init #(
  parameter int W       = 24,
  parameter int TIMEOUT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_wr,
  input  logic [3:0]   cpu_wr_off,
  input  logic [W-1:0] cpu_wdata,
  input  logic         cpu_rd,
  input  logic [3:0]   cpu_rd_off,
  output logic [W-1:0] cpu_rdata,
  input  logic         cpu_send,
  output logic         busy,
  output logic         irq,
  output logic         bus_req,
  input  logic         bus_gnt,
  output logic         bus_drive,
  output logic [W-1:0] bus_out,
  output logic         bus_par,
  input  logic         bus_rvalid,
  input  logic [W-1:0] bus_rdata,
  input  logic         bus_rpar
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam int B_OVR = W - 1;
  localparam int B_PAR = W - 2;
  localparam int B_TMO = W - 3;
  localparam logic [3:0] OFF_HDR = 4'd2, OFF_ADR = 4'd4, OFF_DAT = 4'd6, OFF_STS = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_HDR, S_ADR, S_WAIT} st_t;

  st_t              st;
  logic [W-1:0]     hdr_q, adr_q, dat_q, sts_q;
  logic [CNT_W-1:0] cnt;
  logic             fresh;

  assign busy      = (st != S_IDLE);
  assign bus_req   = busy;
  assign bus_drive = (st == S_HDR) || (st == S_ADR);
  assign bus_out   = (st == S_HDR) ? hdr_q :
                     (st == S_ADR) ? {1'b1, adr_q[W-2:0]} : '0;
  assign bus_par   = ^bus_out;

  always_comb begin
    case (cpu_rd_off)
      OFF_HDR: cpu_rdata = hdr_q;
      OFF_ADR: cpu_rdata = adr_q;
      OFF_DAT: cpu_rdata = dat_q;
      OFF_STS: cpu_rdata = sts_q;
      default: cpu_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      hdr_q <= '0;
      adr_q <= '0;
      dat_q <= '0;
      sts_q <= '0;
      cnt   <= '0;
      fresh <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (cpu_rd && cpu_rd_off == OFF_DAT) fresh <= 1'b0;
      if (cpu_wr && st == S_IDLE) begin
        if (cpu_wr_off == OFF_HDR) hdr_q <= cpu_wdata;
        if (cpu_wr_off == OFF_ADR) adr_q <= cpu_wdata;
      end
      case (st)
        S_IDLE: if (cpu_send) st <= S_REQ;
        S_REQ:  if (bus_gnt) st <= S_HDR;
        S_HDR:  st <= S_ADR;
        S_ADR: begin
          st  <= S_WAIT;
          cnt <= '0;
        end
        S_WAIT: begin
          if (bus_rvalid) begin
            dat_q        <= bus_rdata;
            sts_q        <= '0;
            sts_q[B_OVR] <= fresh;
            sts_q[B_PAR] <= (^bus_rdata) != bus_rpar;
            fresh        <= 1'b1;
            irq          <= 1'b1;
            st           <= S_IDLE;
          end else if (cnt == CNT_W'(TIMEOUT - 1)) begin
            dat_q        <= '0;
            sts_q        <= '0;
            sts_q[B_TMO] <= 1'b1;
            irq          <= 1'b1;
            st           <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icb_msg_init_chk.sv
module icb_msg_init_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         irq,
  input logic         bus_req,
  input logic         bus_gnt,
  input logic         bus_drive,
  input logic [W-1:0] bus_out
);
  p_drive_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> bus_req);

  p_drive_after_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |-> $past(bus_gnt));

  p_two_word_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |=> bus_drive ##1 !bus_drive);

  p_addr_marker_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && $past(bus_drive)) |-> bus_out[W-1]);

  p_irq_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && !bus_req));

  p_done_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
endmodule

bind icb_msg_init icb_msg_init_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_drive(bus_drive), .bus_out(bus_out)
);

// File: tb/test_icb_msg_init.sv
`timescale 1ns/1ps
module test_icb_msg_init;
  localparam int W = 24;
  localparam int T = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_send = 1'b0;
  logic [3:0]   cpu_wr_off = '0, cpu_rd_off = '0;
  logic [W-1:0] cpu_wdata = '0, cpu_rdata;
  logic         busy, irq, bus_req, bus_drive, bus_par;
  logic         bus_gnt = 1'b0, bus_rvalid = 1'b0, bus_rpar = 1'b0;
  logic [W-1:0] bus_out, bus_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  icb_msg_init #(.W(W), .TIMEOUT(T)) i_icb_msg_init (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr(cpu_wr), .cpu_wr_off(cpu_wr_off), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rd_off(cpu_rd_off), .cpu_rdata(cpu_rdata),
    .cpu_send(cpu_send), .busy(busy), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_drive(bus_drive),
    .bus_out(bus_out), .bus_par(bus_par),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rpar(bus_rpar)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [W-1:0] d);
    cpu_wr = 1'b1; cpu_wr_off = off; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, input bit consume, output logic [W-1:0] d);
    cpu_rd_off = off; cpu_rd = consume;
    #0.5;
    d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  // rdly: wait phase cycles before reply (1..T), 0 = no reply
  task automatic run_msg(input logic [W-1:0] h, input logic [W-1:0] a, input int gdly,
                         input int rdly, input logic [W-1:0] rep, input bit badpar);
    wr(4'd2, h);
    wr(4'd4, a);
    cpu_send = 1'b1;
    @(negedge clk);
    cpu_send = 1'b0;
    chk("R2 busy/req after send", {busy, bus_req, bus_drive}, 3'b110);
    for (int i = 0; i < gdly; i++) begin
      @(negedge clk);
      chk("R2 no drive before grant", {bus_req, bus_drive}, 2'b10);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    chk("R3 header word", bus_out, h);
    chk("R3 header drive", bus_drive, 1'b1);
    chk("R7 out parity even", bus_par, ^h);
    @(negedge clk);
    chk("R4 address word", bus_out, a | (1 << 23));
    if (rdly > 0) begin
      repeat (rdly) @(negedge clk);
      chk("R5 still waiting", {busy, irq}, 2'b10);
      bus_rvalid = 1'b1; bus_rdata = rep; bus_rpar = (^rep) ^ badpar;
      @(negedge clk);
      bus_rvalid = 1'b0;
    end else begin
      repeat (T) @(negedge clk);
      chk("R6 no early timeout", {busy, irq}, 2'b10);
      @(negedge clk);
    end
    chk("R5 irq and release", {irq, busy, bus_req, bus_drive}, 4'b1000);
    @(negedge clk);
    chk("R5 irq one cycle", irq, 1'b0);
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    chk("R1 reset outputs", {busy, irq, bus_req, bus_drive}, 4'b0000);
    for (int o = 2; o <= 8; o += 2) begin
      rd(4'(o), 1'b0, d);
      chk("R1 reset slot zero", d, '0);
    end
  endtask

  task automatic t_basic;
    logic [W-1:0] d;
    run_msg(24'h003_001, 24'h40_0A55, 2, 3, 24'hBEEF12, 1'b0);
    rd(4'd6, 1'b1, d);
    chk("R5 data slot", d, 24'hBEEF12);
    rd(4'd8, 1'b0, d);
    chk("R5 status clean", d, '0);
    run_msg(24'h7FF_800, 24'h00_1234, 0, 1, 24'h000001, 1'b0);
    rd(4'd6, 1'b1, d);
    chk("R5 data slot second", d, 24'h000001);
  endtask

  task automatic t_parity;
    logic [W-1:0] d;
    run_msg(24'h002_005, 24'h20_0000, 1, 2, 24'h123456, 1'b1);
    rd(4'd8, 1'b0, d);
    chk("R7 parity error bit", d, 24'h400000);
    rd(4'd6, 1'b1, d);
    chk("R7 data kept", d, 24'h123456);
  endtask

  task automatic t_overrun;
    logic [W-1:0] d;
    run_msg(24'h004_001, 24'h00_0010, 0, 2, 24'hAAAAAA, 1'b0);
    run_msg(24'h004_001, 24'h00_0020, 0, 2, 24'h555555, 1'b0);
    rd(4'd8, 1'b0, d);
    chk("R8 overrun bit", d, 24'h800000);
    rd(4'd6, 1'b1, d);
    chk("R8 newest data", d, 24'h555555);
    run_msg(24'h004_001, 24'h00_0030, 0, 2, 24'h0F0F0F, 1'b0);
    rd(4'd8, 1'b0, d);
    chk("R8 status replaced", d, '0);
    rd(4'd6, 1'b1, d);
  endtask

  task automatic t_timeout;
    logic [W-1:0] d;
    run_msg(24'h009_001, 24'h00_0777, 0, 0, '0, 1'b0);
    rd(4'd8, 1'b0, d);
    chk("R6 timeout bit", d, 24'h200000);
    rd(4'd6, 1'b1, d);
    chk("R6 data zero", d, '0);
    run_msg(24'h009_001, 24'h00_0778, 0, T, 24'hC0FFEE, 1'b0);
    rd(4'd8, 1'b0, d);
    chk("R6 last-cycle reply accepted", d, '0);
    rd(4'd6, 1'b1, d);
    chk("R6 last-cycle data", d, 24'hC0FFEE);
  endtask

  task automatic t_busy_ignore;
    logic [W-1:0] d;
    wr(4'd2, 24'h00A_00B);
    wr(4'd4, 24'h00_0042);
    cpu_send = 1'b1;
    @(negedge clk);
    cpu_send = 1'b0;
    wr(4'd2, 24'hFFF_FFF);
    wr(4'd4, 24'h7F_FFFF);
    cpu_send = 1'b1;
    @(negedge clk);
    cpu_send = 1'b0;
    rd(4'd2, 1'b0, d);
    chk("R9 header write ignored", d, 24'h00A_00B);
    rd(4'd4, 1'b0, d);
    chk("R9 address write ignored", d, 24'h00_0042);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    chk("R9 old header driven", bus_out, 24'h00A_00B);
    @(negedge clk);
    chk("R9 old address driven", bus_out, 24'h80_0042);
    @(negedge clk);
    bus_rvalid = 1'b1; bus_rdata = 24'h000111; bus_rpar = ^24'h000111;
    @(negedge clk);
    bus_rvalid = 1'b0;
    chk("R9 done", {irq, busy}, 2'b10);
    repeat (4) @(negedge clk);
    chk("R9 no second message", {busy, bus_req}, 2'b00);
    rd(4'd6, 1'b1, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_basic;
    t_parity;
    t_overrun;
    t_timeout;
    t_busy_ignore;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule